// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from internal sources into a sticky status vector and presents that vector to a host through a small strobe-based register interface. The host can mask individual sources and inspect status in two ways. The nondestructive view leaves status untouched. The clear-on-read view empties it. Individual bits can also be retired through an acknowledge port. A single host interrupt line summarises every pending, unmasked source.

The mask can be replaced as a whole or edited bit by bit through dedicated set and clear ports, so that software never needs a read-modify-write. Two static configuration inputs decide whether the host line is driven at all and which level means "active". Only a fixed subset of the status positions is implemented. The remaining positions are reserved: they never latch and always read as zero.

Top module: `hint_ctrl`

## Requirements
- R1: After synchronous reset the status vector is zero, the mask is 0x00001 (only bit 0 masked) and host_irq is low.
- R2: A write to address 0 replaces the mask with the write data; address 0 reads back the mask, with reserved positions zero.
- R3: A write to address 1 sets every mask bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A write to address 2 clears every mask bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A read of address 3 returns the status vector and does not change it.
- R6: A read of address 4 returns the status vector and then clears every status bit.
- R7: A write to address 5 clears every status bit whose write-data bit is 1; bits written as 0 are unaffected.
- R8: An event arriving in the same cycle as a clear-on-read or an acknowledge of its bit leaves that bit set.
- R9: Only positions 0 to 10, 14, 16 and 17 (mask 0x347FF) are implemented; events on other positions are ignored, and those positions read as zero in status and mask.
- R10: With cfg_irq_en high, host_irq is active one cycle after any status bit is set while its mask bit is 0. cfg_irq_active_low set to 1 makes the active level 0. With cfg_irq_en low the line sits at its inactive level.
- R11: Read data and reg_rvalid appear on the cycle after the read strobe; reads of addresses 1, 2, 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 18 | Event pulses from the sources, one bit per source |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cfg_irq_en | input | 1 | Enables the host line |
| cfg_irq_active_low | input | 1 | Selects an active-low host line |
| host_irq | output | 1 | Host interrupt line |

## Verification
A status bit that is wrongly retained or lost shows up on the very next read of either status view. It also shows up one cycle later on host_irq whenever the bit is unmasked. A mask bit that is corrupted by a set or clear write to a neighbouring bit becomes visible at the next mask readback. The same fault gates or exposes the host line within one cycle. The same-cycle race between an event and a clear is driven directly, so losing the event appears as a zero in the following nondestructive read.

// File: rtl/hint_pkg.sv
package hint_pkg;
  localparam int HINT_ADDR_W = 3;

  typedef enum logic [HINT_ADDR_W-1:0] {
    HA_MASK     = 3'd0,
    HA_MASK_SET = 3'd1,
    HA_MASK_CLR = 3'd2,
    HA_STAT_ND  = 3'd3,
    HA_STAT_COR = 3'd4,
    HA_ACK      = 3'd5
  } hint_addr_e;
endpackage

// File: rtl/hint_mask_reg.sv
module hint_mask_reg #(
  parameter int               SRC_W = 18,
  parameter logic [SRC_W-1:0] VALID = 18'h347FF,
  parameter logic [SRC_W-1:0] INIT  = 18'h00001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_direct,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [SRC_W-1:0] wbits,
  output logic [SRC_W-1:0] mask_q
);
  logic [SRC_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_direct)   mask_d = wbits;
    else if (wr_set) mask_d = mask_q | wbits;
    else if (wr_clr) mask_d = mask_q & ~wbits;
    mask_d = mask_d & VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= INIT & VALID;
    else     mask_q <= mask_d;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (mask_q & $past(wbits & VALID)) == $past(wbits & VALID)); // R3
  AST_MASK_SET_KEEP: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (mask_q & $past(~wbits)) == ($past(mask_q) & $past(~wbits))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (mask_q & $past(wbits)) == '0); // R4
  AST_MASK_RSVD: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~VALID) == '0); // R9
endmodule

// File: rtl/hint_status_reg.sv
module hint_status_reg #(
  parameter int               SRC_W = 18,
  parameter logic [SRC_W-1:0] VALID = 18'h347FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] evt,
  input  logic             ack_en,
  input  logic [SRC_W-1:0] ack_bits,
  input  logic             cor_rd,
  output logic [SRC_W-1:0] status_q
);
  logic [SRC_W-1:0] clr_bits;
  logic [SRC_W-1:0] evt_v;

  assign evt_v = evt & VALID;

  always_comb begin
    clr_bits = '0;
    if (ack_en) clr_bits = clr_bits | ack_bits;
    if (cor_rd) clr_bits = '1;
  end

  // new events are merged after the clear so they cannot be lost
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= ((status_q & ~clr_bits) | evt_v) & VALID;
  end

  AST_ND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cor_rd && !ack_en) |=> (status_q & $past(status_q)) == $past(status_q)); // R5
  AST_COR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    cor_rd |=> status_q == $past(evt_v)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_en |=> (status_q & $past(ack_bits & ~evt_v)) == '0); // R7
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt_v) |=> (status_q & $past(evt_v)) == $past(evt_v)); // R8
  AST_STAT_RSVD: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~VALID) == '0); // R9
endmodule

// File: rtl/hint_irq_out.sv
module hint_irq_out #(
  parameter int SRC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] status,
  input  logic [SRC_W-1:0] mask,
  input  logic             cfg_en,
  input  logic             cfg_low,
  output logic             host_irq
);
  logic pending;

  assign pending = |(status & ~mask);

  always_ff @(posedge clk) begin
    if (rst) host_irq <= 1'b0;
    else     host_irq <= (cfg_en & pending) ^ cfg_low;
  end

  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_low && (status != '0) && ((status & mask) == '0)) |=> host_irq); // R10
  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((status & ~mask) == '0) |=> host_irq == $past(cfg_low)); // R10
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> host_irq == $past(cfg_low)); // R10
endmodule

// File: rtl/hint_ctrl.sv
module hint_ctrl
  import hint_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               SRC_W     = 18,
  parameter logic [SRC_W-1:0] VALID     = 18'h347FF,
  parameter logic [SRC_W-1:0] MASK_INIT = 18'h00001
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SRC_W-1:0]       evt_pulse,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [HINT_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic                   reg_rvalid,
  input  logic                   cfg_irq_en,
  input  logic                   cfg_irq_active_low,
  output logic                   host_irq
);
  localparam int PAD_W = DATA_W - SRC_W;

  logic [SRC_W-1:0] wbits;
  logic [PAD_W-1:0] wdata_hi_unused;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] status_q;
  logic             wr_direct, wr_set, wr_clr, wr_ack, rd_cor;
  logic [SRC_W-1:0] rd_mux;

  assign wbits           = reg_wdata[SRC_W-1:0];
  assign wdata_hi_unused = reg_wdata[DATA_W-1:SRC_W];

  assign wr_direct = reg_wr && (reg_addr == HA_MASK);
  assign wr_set    = reg_wr && (reg_addr == HA_MASK_SET);
  assign wr_clr    = reg_wr && (reg_addr == HA_MASK_CLR);
  assign wr_ack    = reg_wr && (reg_addr == HA_ACK);
  assign rd_cor    = reg_rd && (reg_addr == HA_STAT_COR);

  hint_mask_reg #(.SRC_W(SRC_W), .VALID(VALID), .INIT(MASK_INIT)) u_mask (
    .clk(clk), .rst(rst), .wr_direct(wr_direct), .wr_set(wr_set),
    .wr_clr(wr_clr), .wbits(wbits), .mask_q(mask_q)
  );

  hint_status_reg #(.SRC_W(SRC_W), .VALID(VALID)) u_status (
    .clk(clk), .rst(rst), .evt(evt_pulse), .ack_en(wr_ack),
    .ack_bits(wbits), .cor_rd(rd_cor), .status_q(status_q)
  );

  hint_irq_out #(.SRC_W(SRC_W)) u_irq (
    .clk(clk), .rst(rst), .status(status_q), .mask(mask_q),
    .cfg_en(cfg_irq_en), .cfg_low(cfg_irq_active_low), .host_irq(host_irq)
  );

  always_comb begin
    case (reg_addr)
      HA_MASK:     rd_mux = mask_q;
      HA_STAT_ND,
      HA_STAT_COR: rd_mux = status_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= {{PAD_W{1'b0}}, rd_mux};
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R11
  AST_COR_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rd_cor |=> reg_rdata[SRC_W-1:0] == $past(status_q)); // R6
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == HA_ACK)) |=> reg_rdata == '0); // R11
endmodule

// File: tb/hint_ctrl_tb.sv
module hint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] evt_pulse = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        cfg_irq_en = 1'b1;
  logic        cfg_irq_active_low = 1'b0;
  logic        host_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  hint_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .cfg_irq_en(cfg_irq_en),
    .cfg_irq_active_low(cfg_irq_active_low), .host_irq(host_irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected read data act=%h exp=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic bus(input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] d, input logic [17:0] e,
                     input logic [31:0] x, input string tag);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; evt_pulse = e;
    if (r) begin exp_q.push_back(x); tag_q.push_back(tag); end
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; evt_pulse = '0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus(1'b1, 1'b0, a, d, '0, '0, "");
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] x, input string tag);
    bus(1'b0, 1'b1, a, '0, '0, x, tag);
  endtask

  task automatic pulse(input logic [17:0] e);
    bus(1'b0, 1'b0, 3'd0, '0, e, '0, "");
  endtask

  task automatic chk_irq(input logic x, input string tag);
    n_chk++;
    if (host_irq !== x) begin
      n_bad++;
      $display("FAIL %s host_irq act=%b exp=%b", tag, host_irq, x);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 reset");
    rd(3'd0, 32'h00001, "R1 mask reset");
    rd(3'd3, 32'h0, "R1 status reset");

    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h347FF, "R2 R9 mask direct write");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R2 mask write zero");

    wr(3'd1, 32'h41);
    rd(3'd0, 32'h41, "R3 mask set");
    wr(3'd1, 32'h4);
    rd(3'd0, 32'h45, "R3 zeros keep bits");
    wr(3'd2, 32'h1);
    rd(3'd0, 32'h44, "R4 mask clear");

    pulse(18'h3C003);
    rd(3'd3, 32'h34003, "R9 reserved event ignored");
    rd(3'd3, 32'h34003, "R5 nondestructive repeat");
    chk_irq(1'b1, "R10 unmasked pending");

    cfg_irq_active_low = 1'b1; @(negedge clk);
    chk_irq(1'b0, "R10 active low");
    cfg_irq_en = 1'b0; @(negedge clk);
    chk_irq(1'b1, "R10 disabled active low idle");
    cfg_irq_active_low = 1'b0; @(negedge clk);
    chk_irq(1'b0, "R10 disabled idle");
    cfg_irq_en = 1'b1; @(negedge clk);
    chk_irq(1'b1, "R10 re-enabled");

    wr(3'd1, 32'h34003); @(negedge clk);
    chk_irq(1'b0, "R10 all masked");
    wr(3'd2, 32'h34003); @(negedge clk);
    chk_irq(1'b1, "R10 unmasked again");
    rd(3'd0, 32'h44, "R4 clear keeps other bits");

    wr(3'd5, 32'h3);
    rd(3'd3, 32'h34000, "R7 acknowledge");
    rd(3'd4, 32'h34000, "R6 clear-on-read data");
    rd(3'd3, 32'h0, "R6 cleared after read");
    chk_irq(1'b0, "R10 nothing pending");

    pulse(18'h10);
    bus(1'b0, 1'b1, 3'd4, '0, 18'h4, 32'h10, "R6 read before race");
    rd(3'd3, 32'h4, "R8 event beats clear-on-read");
    bus(1'b1, 1'b0, 3'd5, 32'h4, 18'h4, '0, "");
    rd(3'd3, 32'h4, "R8 event beats acknowledge");
    wr(3'd5, 32'h4);
    rd(3'd3, 32'h0, "R7 final acknowledge");

    rd(3'd1, 32'h0, "R11 set port reads zero");
    rd(3'd5, 32'h0, "R11 ack port reads zero");
    rd(3'd7, 32'h0, "R11 unused address reads zero");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 missing read data act=%0d exp=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule